// File: doc/BRIEF.md
# Command Processor Control Register Bank

This block is the host-visible register bank of a data-unpacking command processor. A host bus reaches it through a word address. Every register occupies a 16-byte slot, and only the first 32-bit word of the slot holds data. The bank keeps the status, error, mark, mode, mask, cycle, count, code, interrupt-top, buffer-management, row and column registers. The execution engine, which sits outside this block, loads all of them except the command register through a separate update port. From the host side only the error and mark registers can be written. Host writes to any other storage register are refused.

A write-only command register drives the unit's control actions. In a single write it can clear the stall and error status, request a stop, force a break, or reset the whole unit. The bits take effect in a fixed order from least to most overriding, so a reset bit wins over everything else in the same word. The stop request comes out as a level, `stop_pending`, and a reset shows as a one-cycle pulse on `unit_reset`. The parameter `FULL` selects one of two builds. The full build has the five buffer-management registers. The reduced build has no storage for them, so they read as zero.

Top module: `cmdproc_regbank`

## Requirements
- R1: Bit fields of `bus_addr` (a word address): bits [ADDR_W-3:2] give the register index and bits [1:0] give the word within the slot. Only word 0 carries data. A read of words 1 to 3 returns zero. A write to words 1 to 3 changes nothing and raises no error.
- R2: A read presents its data on `bus_rdata` with `bus_rd_valid` high on the clock edge after `bus_rd`. While no read is answered, `bus_rdata` is zero.
- R3: The command register (index 1) always reads zero.
- R4: Command bit 3 (status clear) zeroes status bits [5:0] (stop stall, forced break, interrupt stall, interrupt, error 0, error 1) and cancels a pending stop. Status bit 6 (mark detected) and bits above it are kept.
- R5: Command bit 2 sets `stop_pending` and command bit 1 sets status bit 1. Both act after the status clear in the same write, so 0xC leaves a stop pending and 0xA leaves status bit 1 set.
- R6: Command bit 0 zeroes every register and `stop_pending`, and pulses `unit_reset` high for one cycle. It overrides the other bits in the same write.
- R7: A host write to the error register (index 2) replaces only bits [2:0].
- R8: A host write to the mark register (index 3) replaces bits [15:0], keeps bits [31:16], and clears status bit 6.
- R9: A word-0 host write to any index other than 1, 2 or 3 (read-only indices 0 and 4 to 23, or an index of 24 or more) raises `bus_wr_err` for one cycle, on the edge after the write, and leaves every register unchanged.
- R10: In the reduced build (`FULL`=0), indices 11 to 15 read zero and engine writes to them are dropped. In the full build they hold the value last written by the engine.
- R11: The engine port writes the full 32-bit value of any present register except the command register. If a host write lands in the same cycle, its effects are applied on top of the engine value.
- R12: While the synchronous reset `rst` is high, all registers, `stop_pending`, `unit_reset`, `bus_wr_err`, `bus_rd_valid` and `bus_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | ADDR_W-2 | Host word address relative to the bank base |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rd_valid | output | 1 | Read data valid |
| bus_wr_err | output | 1 | One-cycle pulse for a refused host write |
| eng_we | input | 1 | Engine register update strobe |
| eng_idx | input | ADDR_W-4 | Engine target register index |
| eng_wdata | input | 32 | Engine update value |
| stop_pending | output | 1 | Stop requested and not yet cleared |
| unit_reset | output | 1 | One-cycle unit reset pulse |

## Verification
The bound assertions check these rules on every cycle:
- the command register reads zero;
- every read is answered on the next edge;
- writes to read-only slots always raise the error pulse, and writes to upper words never do;
- the stop, clear and reset bits drive `stop_pending` and `unit_reset`;
- the reduced build returns zero for the buffer-management slots.

Other behaviour can only be shown by the bench, through multi-step sequences that read values back. This covers the bit order inside one command write, the partial-field updates of the error and mark registers, the mark write clearing the status flag, refused writes leaving state untouched, and the engine and the host writing the same register in one cycle.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam int DW   = 32;
  localparam int NREG = 24;

  localparam int IX_STAT  = 0;
  localparam int IX_CMD   = 1;
  localparam int IX_ERR   = 2;
  localparam int IX_MARK  = 3;
  localparam int IX_BUF_LO = 11;
  localparam int IX_BUF_HI = 15;

  localparam int ST_BRK  = 1;
  localparam int ST_MARK = 6;

  localparam int CB_RESET = 0;
  localparam int CB_BREAK = 1;
  localparam int CB_STOP  = 2;
  localparam int CB_CLEAR = 3;

  localparam int ERR_W  = 3;
  localparam int MARK_W = 16;
  localparam logic [DW-1:0] ST_CLEAR_MASK = 32'h0000_003F;

  typedef struct packed {
    logic word0;
    logic readable;
    logic is_cmd;
    logic is_err;
    logic is_mark;
    logic reject;
  } dec_t;

  function automatic logic is_buf_reg(input int unsigned idx);
    return (idx >= IX_BUF_LO) && (idx <= IX_BUF_HI);
  endfunction

  // slot has storage in this build
  function automatic logic reg_present(input int unsigned idx, input bit full);
    return (idx < NREG) && (idx != IX_CMD) && (full || !is_buf_reg(idx));
  endfunction
endpackage

// File: rtl/cpr_decode.sv
module cpr_decode
  import cpr_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter bit FULL   = 1'b1,
  localparam int IDX_W = ADDR_W - 4
) (
  input  logic [ADDR_W-3:0] waddr,
  output logic [IDX_W-1:0]  idx,
  output dec_t              dec
);
  always_comb begin
    int unsigned iu;
    idx = waddr[ADDR_W-3:2];
    iu  = int'(idx);
    dec.word0    = (waddr[1:0] == 2'b00);
    dec.readable = dec.word0 && reg_present(iu, FULL);
    dec.is_cmd   = dec.word0 && (iu == IX_CMD);
    dec.is_err   = dec.word0 && (iu == IX_ERR);
    dec.is_mark  = dec.word0 && (iu == IX_MARK);
    dec.reject   = dec.word0 && !(dec.is_cmd || dec.is_err || dec.is_mark);
  end
endmodule

// File: rtl/cpr_regfile.sv
module cpr_regfile
  import cpr_pkg::*;
#(
  parameter bit FULL  = 1'b1,
  parameter int IDX_W = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     eng_we,
  input  logic [IDX_W-1:0]         eng_idx,
  input  logic [DW-1:0]            eng_wdata,
  input  logic                     host_we,
  input  dec_t                     dec,
  input  logic [DW-1:0]            host_wdata,
  output logic [NREG-1:0][DW-1:0]  regs_o,
  output logic                     stop_pending_o,
  output logic                     unit_reset_o
);
  logic [DW-1:0] cur [NREG];
  logic [DW-1:0] nxt [NREG];
  logic          stop_q, stop_d;
  logic          rst_pulse_q, rst_pulse_d;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      nxt[i] = cur[i];
      if (eng_we && eng_idx == IDX_W'(i) && reg_present(i, FULL))
        nxt[i] = eng_wdata;
    end
    stop_d      = stop_q;
    rst_pulse_d = 1'b0;
    if (host_we && dec.is_cmd) begin
      // least to most overriding
      if (host_wdata[CB_CLEAR]) begin
        nxt[IX_STAT] = nxt[IX_STAT] & ~ST_CLEAR_MASK;
        stop_d       = 1'b0;
      end
      if (host_wdata[CB_STOP])  stop_d = 1'b1;
      if (host_wdata[CB_BREAK]) nxt[IX_STAT][ST_BRK] = 1'b1;
      if (host_wdata[CB_RESET]) begin
        for (int i = 0; i < NREG; i++) nxt[i] = '0;
        stop_d      = 1'b0;
        rst_pulse_d = 1'b1;
      end
    end
    if (host_we && dec.is_err)
      nxt[IX_ERR][ERR_W-1:0] = host_wdata[ERR_W-1:0];
    if (host_we && dec.is_mark) begin
      nxt[IX_MARK][MARK_W-1:0] = host_wdata[MARK_W-1:0];
      nxt[IX_STAT][ST_MARK]    = 1'b0;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    if (reg_present(g, FULL)) begin : g_store
      always_ff @(posedge clk) begin
        if (rst) cur[g] <= '0;
        else     cur[g] <= nxt[g];
      end
    end else begin : g_empty
      assign cur[g] = '0;
    end
    assign regs_o[g] = cur[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q      <= 1'b0;
      rst_pulse_q <= 1'b0;
    end else begin
      stop_q      <= stop_d;
      rst_pulse_q <= rst_pulse_d;
    end
  end

  assign stop_pending_o = stop_q;
  assign unit_reset_o   = rst_pulse_q;
endmodule

// File: rtl/cpr_readmux.sv
module cpr_readmux
  import cpr_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd,
  input  logic [IDX_W-1:0]        idx,
  input  logic                    readable,
  input  logic [NREG-1:0][DW-1:0] regs,
  output logic [DW-1:0]           rdata,
  output logic                    rvalid
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NREG; i++)
      if (idx == IDX_W'(i)) sel = regs[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= (rd && readable) ? sel : '0;
      rvalid <= rd;
    end
  end
endmodule

// File: rtl/cmdproc_regbank.sv
module cmdproc_regbank
  import cpr_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter bit FULL   = 1'b1,
  localparam int IDX_W = ADDR_W - 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-3:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rd_valid,
  output logic              bus_wr_err,
  input  logic              eng_we,
  input  logic [IDX_W-1:0]  eng_idx,
  input  logic [DW-1:0]     eng_wdata,
  output logic              stop_pending,
  output logic              unit_reset
);
  logic [IDX_W-1:0]        idx;
  dec_t                    dec;
  logic [NREG-1:0][DW-1:0] regs;

  cpr_decode #(.ADDR_W(ADDR_W), .FULL(FULL)) u_dec (
    .waddr (bus_addr),
    .idx   (idx),
    .dec   (dec)
  );

  cpr_regfile #(.FULL(FULL), .IDX_W(IDX_W)) u_regs (
    .clk            (clk),
    .rst            (rst),
    .eng_we         (eng_we),
    .eng_idx        (eng_idx),
    .eng_wdata      (eng_wdata),
    .host_we        (bus_wr),
    .dec            (dec),
    .host_wdata     (bus_wdata),
    .regs_o         (regs),
    .stop_pending_o (stop_pending),
    .unit_reset_o   (unit_reset)
  );

  cpr_readmux #(.IDX_W(IDX_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd       (bus_rd),
    .idx      (idx),
    .readable (dec.readable),
    .regs     (regs),
    .rdata    (bus_rdata),
    .rvalid   (bus_rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_wr_err <= 1'b0;
    else     bus_wr_err <= bus_wr && dec.reject;
  end
endmodule

// File: rtl/cpr_regbank_chk.sv
module cpr_regbank_chk #(
  parameter int ADDR_W = 9,
  parameter bit FULL   = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-3:0] bus_addr,
  input logic [2:0]        cmd_bits,   // {clear, stop, reset}
  input logic [31:0]       bus_rdata,
  input logic              bus_rd_valid,
  input logic              bus_wr_err,
  input logic              stop_pending,
  input logic              unit_reset
);
  logic [ADDR_W-5:0] a_idx;
  logic              a_w0;
  logic              a_ro;
  logic              cmd_wr;
  assign a_idx  = bus_addr[ADDR_W-3:2];
  assign a_w0   = (bus_addr[1:0] == 2'b00);
  assign a_ro   = !(a_idx == 1 || a_idx == 2 || a_idx == 3);
  assign cmd_wr = bus_wr && a_w0 && (a_idx == 1);

  assert_cmd_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
    bus_rd && a_idx == 1 |=> bus_rdata == 32'h0);
  assert_read_answered_R2: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rd_valid);
  assert_idle_rdata_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == 32'h0 && !bus_rd_valid));
  assert_upper_word_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    bus_wr && !a_w0 |=> !bus_wr_err);
  assert_refused_write_R9: assert property (@(posedge clk) disable iff (rst)
    bus_wr && a_w0 && a_ro |=> bus_wr_err);
  assert_stop_request_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_wr && cmd_bits[1] && !cmd_bits[0] |=> stop_pending);
  assert_clear_cancels_stop_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_wr && cmd_bits[2] && !cmd_bits[1] |=> !stop_pending);
  assert_reset_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_wr && cmd_bits[0] |=> (unit_reset && !stop_pending));
  assert_reduced_buf_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !FULL && bus_rd && a_idx >= 11 && a_idx <= 15 |=> bus_rdata == 32'h0);
endmodule

bind cmdproc_regbank cpr_regbank_chk #(.ADDR_W(ADDR_W), .FULL(FULL)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_addr     (bus_addr),
  .cmd_bits     ({bus_wdata[3:2], bus_wdata[0]}),
  .bus_rdata    (bus_rdata),
  .bus_rd_valid (bus_rd_valid),
  .bus_wr_err   (bus_wr_err),
  .stop_pending (stop_pending),
  .unit_reset   (unit_reset)
);

// File: tb/test_cmdproc_regbank.sv
module test_cmdproc_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 9;
  localparam int IDX_W  = ADDR_W - 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, eng_we = 1'b0;
  logic [ADDR_W-3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, eng_wdata = '0;
  logic [IDX_W-1:0] eng_idx = '0;

  logic [31:0] rdata [2];
  logic rvalid [2], wr_err [2], stop_p [2], ureset [2];

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdproc_regbank #(.ADDR_W(ADDR_W), .FULL(1'b1)) i_cmdproc_regbank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata[0]), .bus_rd_valid(rvalid[0]),
    .bus_wr_err(wr_err[0]), .eng_we(eng_we), .eng_idx(eng_idx), .eng_wdata(eng_wdata),
    .stop_pending(stop_p[0]), .unit_reset(ureset[0]));

  cmdproc_regbank #(.ADDR_W(ADDR_W), .FULL(1'b0)) i_cmdproc_regbank_lite (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata[1]), .bus_rd_valid(rvalid[1]),
    .bus_wr_err(wr_err[1]), .eng_we(eng_we), .eng_idx(eng_idx), .eng_wdata(eng_wdata),
    .stop_pending(stop_p[1]), .unit_reset(ureset[1]));

  // reference model: variant 0 full, variant 1 reduced
  logic [31:0] m [2][32];
  logic        ms [2];

  function automatic bit present(int v, int i);
    return i < 24 && i != 1 && (v == 0 || !(i >= 11 && i <= 15));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle();
    logic [31:0] n [2][32];
    logic [31:0] e_rd [2];
    logic e_rv [2], e_err [2], e_ur [2], e_st [2];
    int ai, wo;
    ai = int'(bus_addr[ADDR_W-3:2]);
    wo = int'(bus_addr[1:0]);
    for (int v = 0; v < 2; v++) begin
      for (int i = 0; i < 32; i++) n[v][i] = m[v][i];
      e_st[v] = ms[v];
      e_ur[v] = 1'b0;
      if (rst) begin
        for (int i = 0; i < 32; i++) n[v][i] = '0;
        e_st[v] = 0; e_rd[v] = '0; e_rv[v] = 0; e_err[v] = 0;
      end else begin
        e_rv[v]  = bus_rd;
        e_rd[v]  = (bus_rd && wo == 0 && present(v, ai)) ? m[v][ai] : 32'h0;
        e_err[v] = bus_wr && wo == 0 && !(ai inside {1, 2, 3});
        if (eng_we && present(v, int'(eng_idx))) n[v][eng_idx] = eng_wdata;
        if (bus_wr && wo == 0) begin
          if (ai == 1) begin
            if (bus_wdata[3]) begin n[v][0] &= ~32'h3F; e_st[v] = 0; end
            if (bus_wdata[2]) e_st[v] = 1;
            if (bus_wdata[1]) n[v][0][1] = 1'b1;
            if (bus_wdata[0]) begin
              for (int i = 0; i < 32; i++) n[v][i] = '0;
              e_st[v] = 0; e_ur[v] = 1;
            end
          end else if (ai == 2) n[v][2][2:0] = bus_wdata[2:0];
          else if (ai == 3) begin
            n[v][3][15:0] = bus_wdata[15:0];
            n[v][0][6] = 1'b0;
          end
        end
      end
    end
    @(posedge clk);
    #1;
    for (int v = 0; v < 2; v++) begin
      chk("R2 model rdata", rdata[v], e_rd[v]);
      chk("R2 model rd_valid", 32'(rvalid[v]), 32'(e_rv[v]));
      chk("R9 model wr_err", 32'(wr_err[v]), 32'(e_err[v]));
      chk("R6 model unit_reset", 32'(ureset[v]), 32'(e_ur[v]));
      chk("R5 model stop_pending", 32'(stop_p[v]), 32'(e_st[v]));
      for (int i = 0; i < 32; i++) m[v][i] = n[v][i];
      ms[v] = e_st[v];
    end
  endtask

  task automatic wr(int idx, int word, logic [31:0] d);
    bus_wr = 1; bus_addr = {IDX_W'(idx), 2'(word)}; bus_wdata = d;
    cycle();
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(int idx, int word, output logic [31:0] full_v, output logic [31:0] lite_v);
    bus_rd = 1; bus_addr = {IDX_W'(idx), 2'(word)};
    cycle();
    full_v = rdata[0]; lite_v = rdata[1];
    bus_rd = 0;
  endtask

  task automatic eng(int idx, logic [31:0] d);
    eng_we = 1; eng_idx = IDX_W'(idx); eng_wdata = d;
    cycle();
    eng_we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] f, l;
    for (int v = 0; v < 2; v++) begin
      for (int i = 0; i < 32; i++) m[v][i] = '0;
      ms[v] = 0;
    end
    #1;
    repeat (3) cycle();
    rst = 0;

    rd(0, 0, f, l);              chk("R12 status after reset", f, 32'h0);
    chk("R12 stop after reset", 32'(stop_p[0]), 32'h0);
    eng(0, 32'hFFFF_FFFF);
    rd(0, 0, f, l);              chk("R11 engine load status", f, 32'hFFFF_FFFF);
    wr(1, 0, 32'h8);
    rd(0, 0, f, l);              chk("R4 clear keeps bit6 up", f, 32'hFFFF_FFC0);
    wr(1, 0, 32'h4);             chk("R5 stop request", 32'(stop_p[0]), 32'h1);
    wr(1, 0, 32'h8);             chk("R4 clear cancels stop", 32'(stop_p[0]), 32'h0);
    wr(1, 0, 32'hC);             chk("R5 stop after clear", 32'(stop_p[0]), 32'h1);
    wr(1, 0, 32'hA);
    rd(0, 0, f, l);              chk("R5 break after clear", f, 32'hFFFF_FFC2);
    chk("R4 clear+break drops stop", 32'(stop_p[0]), 32'h0);
    rd(1, 0, f, l);              chk("R3 command reads zero", f, 32'h0);

    eng(2, 32'hABCD_0000);
    wr(2, 0, 32'hFFFF_FFFD);
    rd(2, 0, f, l);              chk("R7 error low bits", f, 32'hABCD_0005);

    eng(0, 32'hFFFF_FFFF);
    eng(3, 32'hAAAA_0000);
    wr(3, 0, 32'h1234_5678);
    rd(3, 0, f, l);              chk("R8 mark low half", f, 32'hAAAA_5678);
    rd(0, 0, f, l);              chk("R8 mark flag cleared", f, 32'hFFFF_FFBF);

    eng(5, 32'h11);
    wr(5, 0, 32'hFF);            chk("R9 read-only write refused", 32'(wr_err[0]), 32'h1);
    rd(5, 0, f, l);              chk("R9 read-only unchanged", f, 32'h11);
    wr(30, 0, 32'h1);            chk("R9 out-of-range refused", 32'(wr_err[0]), 32'h1);
    eng(11, 32'h77);
    wr(11, 0, 32'h0);            chk("R9 buffer reg refused lite", 32'(wr_err[1]), 32'h1);
    rd(11, 0, f, l);             chk("R10 full keeps buffer reg", f, 32'h77);
    chk("R10 reduced reads zero", l, 32'h0);

    wr(3, 2, 32'h0);             chk("R1 upper word no error", 32'(wr_err[0]), 32'h0);
    rd(3, 0, f, l);              chk("R1 upper word write no effect", f, 32'hAAAA_5678);
    rd(3, 1, f, l);              chk("R1 upper word reads zero", f, 32'h0);

    eng_we = 1; eng_idx = IDX_W'(3); eng_wdata = 32'hFFFF_FFFF;
    wr(3, 0, 32'h0);
    eng_we = 0;
    rd(3, 0, f, l);              chk("R11 host over engine", f, 32'hFFFF_0000);

    wr(1, 0, 32'h4);
    wr(1, 0, 32'h7);             chk("R6 reset pulse", 32'(ureset[0]), 32'h1);
    chk("R6 reset beats stop", 32'(stop_p[0]), 32'h0);
    rd(0, 0, f, l);              chk("R6 pulse one cycle", 32'(ureset[0]), 32'h0);
    chk("R6 status zeroed", f, 32'h0);
    rd(3, 0, f, l);              chk("R6 mark zeroed", f, 32'h0);

    eng(6, 32'h5);
    rst = 1; cycle(); rst = 0;
    rd(6, 0, f, l);              chk("R12 reset clears count", f, 32'h0);

    repeat (2) cycle();
    finish_run();
  end
endmodule